// File: doc/BRIEF.md
# Mirrored Two-Port Switch Allocator

This block decides, every cycle, which virtual channel (VC) of each of the two input ports of one dimension module may cross the module's 2x2 crossbar, and on which output. Each of the two outputs points one way along the dimension: output 1 is the high side (east or south) and output 0 is the low side (west or north). Every VC offers three bits: a request, a direction bit (1 = high output, 0 = low output) and a ready flag. The ready flag says that the VC already owns a downstream VC and that the next router has buffer space.

Each input port has two round-robin local arbiters, one for each direction. Only port 0 has a global arbiter, which picks its direction. Port 0 sees which directions port 1 is asking for, so it can pick in a way that lets both ports move. Port 1 never runs a global arbitration of its own. It takes the direction opposite to port 0's choice and grants the winner of its own local arbiter for that direction. When port 0 is idle, port 1 alternates between its two directions on its own. The decision is made in one pass. The grants are registered and drive the crossbar select of the following traversal stage.

Top module: `mirror_sa`

## Requirements
- R1: A VC is granted only if its request and ready bits were both 1 in the cycle before the grant. The direction reported with the grant equals that VC's direction bit from the same cycle.
- R2: Each port's grant vector has at most one bit set.
- R3: Grants appear on the outputs exactly one clock after the request cycle. After reset all grants, directions, output valids and output sources are 0.
- R4: Port 0 is granted in every cycle that follows a cycle in which it had at least one eligible VC.
- R5: When both ports are granted in the same cycle, their directions differ.
- R6: Both ports are granted whenever a two-way match existed, meaning port 0 could use one direction and port 1 the other.
- R7: When port 0 is granted direction d and port 1 has no eligible VC for the opposite direction, port 1 gets no grant.
- R8: When port 0 has no eligible VC, port 1 is granted if it has one. If port 1 has both directions, it alternates between them, starting with the high direction after reset.
- R9: Within one port and one direction, VCs are served round robin starting from VC0 after reset. Priority moves past a VC only when that VC is actually granted.
- R10: When port 0 holds both directions and port 1's requests do not force a choice (port 1 holds both directions or none), port 0 takes the direction opposite to its previously granted one. After reset it starts with the high direction.
- R11: out_vld_o[d] is 1 when a granted port goes in direction d. out_src_o[d] then gives that port's index (0 or 1), and it is 0 when out_vld_o[d] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p0_req_i | input | NUM_VC | Port 0 per-VC switch request |
| p0_dir_i | input | NUM_VC | Port 0 per-VC direction (1 = high output) |
| p0_rdy_i | input | NUM_VC | Port 0 per-VC ready (VC allocated, downstream credit) |
| p1_req_i | input | NUM_VC | Port 1 per-VC switch request |
| p1_dir_i | input | NUM_VC | Port 1 per-VC direction (1 = high output) |
| p1_rdy_i | input | NUM_VC | Port 1 per-VC ready |
| p0_gnt_o | output | NUM_VC | Port 0 registered one-hot grant |
| p0_dir_o | output | 1 | Direction of port 0 grant (0 when no grant) |
| p1_gnt_o | output | NUM_VC | Port 1 registered one-hot grant |
| p1_dir_o | output | 1 | Direction of port 1 grant (0 when no grant) |
| out_vld_o | output | 2 | Crossbar output d is driven this cycle |
| out_src_o | output | 2 | Input port index driving output d |

## Verification
Suppose the global direction pointer ends up in the wrong state. Port 0 would then go the wrong way on the next cycle in which it holds both directions and port 1 leaves the choice open, and that shows on p0_dir_o one clock later. A wrong pointer in a local arbiter shows as the wrong VC in a rotation of same-direction requests within a few grants. A wrong use of port 1's state shows at once as a lone grant in a cycle where a two-way match was available. The stimulus arranges each of these cases and predicts the exact grant for every cycle, so any divergence is visible within one or two cycles.

// File: rtl/mirror_sa_pkg.sv
package mirror_sa_pkg;
  localparam int NUM_DIR = 2;
  localparam logic DIR_LO = 1'b0;
  localparam logic DIR_HI = 1'b1;
endpackage

// File: rtl/rr_arb.sv
module rr_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, win;
  logic          found;

  always_comb begin
    gnt_o = '0;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        win        = IW'(idx);
      end
    end
  end

  assign any_o = found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i && found) ptr_q <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
  end

  AST_RR_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~req_i) == '0)); // R1
endmodule

// File: rtl/port_front.sv
module port_front
  import mirror_sa_pkg::*;
#(
  parameter int NUM_VC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_VC-1:0] req_i,
  input  logic [NUM_VC-1:0] dir_i,
  input  logic [NUM_VC-1:0] rdy_i,
  input  logic              take_i,
  input  logic              sel_dir_i,
  output logic [NUM_DIR-1:0] has_o,
  output logic [NUM_VC-1:0] gnt_o
);
  logic [NUM_VC-1:0] elig;
  logic [NUM_VC-1:0] elig_d [NUM_DIR];
  logic [NUM_VC-1:0] gnt_d  [NUM_DIR];

  assign elig = req_i & rdy_i;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    assign elig_d[d] = elig & ((d == 1) ? dir_i : ~dir_i);
    rr_arb #(.N(NUM_VC)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (elig_d[d]),
      .adv_i  (take_i && (sel_dir_i == 1'(d))),
      .gnt_o  (gnt_d[d]),
      .any_o  (has_o[d])
    );
  end

  assign gnt_o = take_i ? gnt_d[sel_dir_i] : '0;

  AST_TAKE_HAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (|gnt_o)); // R2
endmodule

// File: rtl/dir_pick.sv
module dir_pick
  import mirror_sa_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DIR-1:0] has0_i,
  input  logic [NUM_DIR-1:0] has1_i,
  output logic               take0_o,
  output logic               dir0_o,
  output logic               take1_o,
  output logic               dir1_o
);
  logic g_pri_q, p1_pri_q;

  always_comb begin
    take0_o = 1'b0;
    dir0_o  = DIR_LO;
    if (|has0_i) begin
      take0_o = 1'b1;
      if (!(&has0_i))            dir0_o = has0_i[1];
      else if (has1_i == 2'b10)  dir0_o = DIR_LO; // let port 1 go high
      else if (has1_i == 2'b01)  dir0_o = DIR_HI; // let port 1 go low
      else                       dir0_o = g_pri_q;
      dir1_o  = ~dir0_o;
      take1_o = has1_i[dir1_o];
    end else begin
      dir1_o  = (&has1_i) ? p1_pri_q : has1_i[1];
      take1_o = |has1_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_pri_q  <= DIR_HI;
      p1_pri_q <= DIR_HI;
    end else begin
      if (take0_o) g_pri_q <= ~dir0_o;
      if (!(|has0_i) && take1_o) p1_pri_q <= ~dir1_o;
    end
  end

  AST_PICK_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take0_o && take1_o) |-> (dir0_o != dir1_o)); // R5
endmodule

// File: rtl/mirror_sa.sv
module mirror_sa
  import mirror_sa_pkg::*;
#(
  parameter int NUM_VC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_VC-1:0] p0_req_i,
  input  logic [NUM_VC-1:0] p0_dir_i,
  input  logic [NUM_VC-1:0] p0_rdy_i,
  input  logic [NUM_VC-1:0] p1_req_i,
  input  logic [NUM_VC-1:0] p1_dir_i,
  input  logic [NUM_VC-1:0] p1_rdy_i,
  output logic [NUM_VC-1:0] p0_gnt_o,
  output logic              p0_dir_o,
  output logic [NUM_VC-1:0] p1_gnt_o,
  output logic              p1_dir_o,
  output logic [1:0]        out_vld_o,
  output logic [1:0]        out_src_o
);
  logic [NUM_DIR-1:0] has0, has1;
  logic               take0, take1, dir0, dir1;
  logic [NUM_VC-1:0]  gnt0, gnt1;

  port_front #(.NUM_VC(NUM_VC)) u_p0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(p0_req_i), .dir_i(p0_dir_i), .rdy_i(p0_rdy_i),
    .take_i(take0), .sel_dir_i(dir0), .has_o(has0), .gnt_o(gnt0)
  );

  port_front #(.NUM_VC(NUM_VC)) u_p1 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(p1_req_i), .dir_i(p1_dir_i), .rdy_i(p1_rdy_i),
    .take_i(take1), .sel_dir_i(dir1), .has_o(has1), .gnt_o(gnt1)
  );

  dir_pick u_pick (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .has0_i(has0), .has1_i(has1),
    .take0_o(take0), .dir0_o(dir0), .take1_o(take1), .dir1_o(dir1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p0_gnt_o <= '0;
      p0_dir_o <= 1'b0;
      p1_gnt_o <= '0;
      p1_dir_o <= 1'b0;
    end else begin
      p0_gnt_o <= gnt0;
      p0_dir_o <= take0 & dir0;
      p1_gnt_o <= gnt1;
      p1_dir_o <= take1 & dir1;
    end
  end

  // traversal-stage crossbar select
  logic p0_act, p1_act;
  assign p0_act = |p0_gnt_o;
  assign p1_act = |p1_gnt_o;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_xsel
    logic p0_here, p1_here;
    assign p0_here      = p0_act && (p0_dir_o == 1'(d));
    assign p1_here      = p1_act && (p1_dir_o == 1'(d));
    assign out_vld_o[d] = p0_here | p1_here;
    assign out_src_o[d] = p1_here & ~p0_here;
  end

  // assertion support: history valid after first post-reset edge
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  logic [NUM_VC-1:0] el0, el1;
  logic e0_hi, e0_lo, e1_hi, e1_lo;
  assign el0   = p0_req_i & p0_rdy_i;
  assign el1   = p1_req_i & p1_rdy_i;
  assign e0_hi = |(el0 & p0_dir_i);
  assign e0_lo = |(el0 & ~p0_dir_i);
  assign e1_hi = |(el1 & p1_dir_i);
  assign e1_lo = |(el1 & ~p1_dir_i);

  AST_P0_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(p0_gnt_o)); // R2
  AST_P1_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(p1_gnt_o)); // R2
  AST_P0_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && p0_act) |-> ((p0_gnt_o & ~$past(el0)) == '0)); // R1
  AST_P1_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && p1_act) |-> ((p1_gnt_o & ~$past(el1)) == '0)); // R1
  AST_P0_DIRMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && p0_act) |-> ((p0_gnt_o & ($past(p0_dir_i) ^ {NUM_VC{p0_dir_o}})) == '0)); // R1
  AST_P0_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(|el0)) |-> p0_act); // R4
  AST_NO_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p0_act && p1_act) |-> (p0_dir_o != p1_dir_o)); // R5
  AST_MAX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past((e0_hi && e1_lo) || (e0_lo && e1_hi))) |-> (p0_act && p1_act)); // R6
  AST_P1_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(!(|el0) && (|el1))) |-> p1_act); // R8
endmodule

// File: tb/sim_mirror_sa.sv
module sim_mirror_sa;
  localparam int CLK_P = 10;
  localparam int NV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NV-1:0] p0_req = '0, p0_dir = '0, p0_rdy = '0;
  logic [NV-1:0] p1_req = '0, p1_dir = '0, p1_rdy = '0;
  logic [NV-1:0] p0_gnt, p1_gnt;
  logic p0_d, p1_d;
  logic [1:0] vld, src;

  always #(CLK_P / 2) clk = ~clk;

  mirror_sa #(.NUM_VC(NV)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .p0_req_i(p0_req), .p0_dir_i(p0_dir), .p0_rdy_i(p0_rdy),
    .p1_req_i(p1_req), .p1_dir_i(p1_dir), .p1_rdy_i(p1_rdy),
    .p0_gnt_o(p0_gnt), .p0_dir_o(p0_d), .p1_gnt_o(p1_gnt), .p1_dir_o(p1_d),
    .out_vld_o(vld), .out_src_o(src)
  );

  typedef struct packed {
    logic [NV-1:0] g0;
    logic          d0;
    logic [NV-1:0] g1;
    logic          d1;
    logic [1:0]    v;
    logic [1:0]    s;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic drive(input logic [NV-1:0] r0, d0, y0, r1, d1, y1,
                       input logic [NV-1:0] eg0, input logic ed0,
                       input logic [NV-1:0] eg1, input logic ed1,
                       input string tag);
    exp_t e;
    @(negedge clk);
    p0_req = r0; p0_dir = d0; p0_rdy = y0;
    p1_req = r1; p1_dir = d1; p1_rdy = y1;
    e.g0 = eg0; e.d0 = ed0; e.g1 = eg1; e.d1 = ed1;
    // R11: output d valid with source port index
    for (int d = 0; d < 2; d++) begin
      logic a0, a1;
      a0 = (eg0 != '0) && (ed0 == 1'(d));
      a1 = (eg1 != '0) && (ed1 == 1'(d));
      e.v[d] = a0 | a1;
      e.s[d] = a1 & ~a0;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: sample one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        exp_t a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {p0_gnt, p0_d, p1_gnt, p1_d, vld, src};
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: got g0=%b d0=%b g1=%b d1=%b vld=%b src=%b exp g0=%b d0=%b g1=%b d1=%b vld=%b src=%b",
                   t, a.g0, a.d0, a.g1, a.d1, a.v, a.s, e.g0, e.d0, e.g1, e.d1, e.v, e.s);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if ({p0_gnt, p0_d, p1_gnt, p1_d, vld, src} !== '0) begin
      n_bad++;
      $display("FAIL R3 reset: got %b exp 0", {p0_gnt, p0_d, p1_gnt, p1_d, vld, src});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: request without ready is ignored
    drive(4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 4'b0000, 0, "R1 not ready");
    // R4 R3: single high request on port 0
    drive(4'b0010, 4'b0010, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1, 4'b0000, 0, "R4 single");
    // R10: port 0 both directions, port 1 silent, alternate
    drive(4'b0011, 4'b0010, 4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 0, 4'b0000, 0, "R10 alt low");
    drive(4'b0011, 4'b0010, 4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1, 4'b0000, 0, "R10 alt high");
    // R6: port 1 high only forces port 0 low
    drive(4'b0011, 4'b0010, 4'b0011, 4'b1000, 4'b1000, 4'b1000, 4'b0001, 0, 4'b1000, 1, "R6 forced match");
    // R7: both only high, port 1 loses
    drive(4'b0100, 4'b0100, 4'b0100, 4'b0001, 4'b0001, 4'b0001, 4'b0100, 1, 4'b0000, 0, "R7 same dir");
    // R8: port 0 idle, port 1 alternates starting high
    drive(4'b0000, 4'b0000, 4'b0000, 4'b0110, 4'b0010, 4'b0110, 4'b0000, 0, 4'b0010, 1, "R8 p1 high");
    drive(4'b0000, 4'b0000, 4'b0000, 4'b0110, 4'b0010, 4'b0110, 4'b0000, 0, 4'b0100, 0, "R8 p1 low");
    // R9: four high VCs on port 0 rotate; pointer left at VC3
    drive(4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b1000, 1, 4'b0000, 0, "R9 rr vc3");
    drive(4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 1, 4'b0000, 0, "R9 rr vc0");
    drive(4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1, 4'b0000, 0, "R9 rr vc1");
    drive(4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 1, 4'b0000, 0, "R9 rr vc2");
    // R5 R10 R11: both ports hold both directions, mirrored
    drive(4'b0011, 4'b0010, 4'b0011, 4'b0011, 4'b0001, 4'b0011, 4'b0001, 0, 4'b0001, 1, "R5 mirror a");
    drive(4'b0011, 4'b0010, 4'b0011, 4'b0011, 4'b0001, 4'b0011, 4'b0010, 1, 4'b0010, 0, "R11 mirror b");
    // R1: requests everywhere but nothing ready
    drive(4'b1111, 4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 0, 4'b0000, 0, "R1 no credit");
    drive(4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 4'b0000, 0, "R3 idle");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule